// File: doc/BRIEF.md
# PHY Control Register with Soft Reset and Loopback

This block is the main control register of a 10 Mbps PHY, reached over a single-word management write port and a combinational read port. Bit 15 is a self-clearing soft reset: writing 1 to it starts a reset sequence of fixed length. While that sequence runs, the bit reads back as 1, the PHY's own register set is held at its defaults through a reset strobe, and management writes are ignored. When the sequence ends, the bit drops to 0 by itself, so software can poll it.

Bit 14 enables internal loopback. When it is set, transmit data and transmit enable are returned to the MAC's receive bus, and the line transmitter is silenced. When it is clear, the block passes data straight through in both directions. Bits 13:0 are read/write storage. Bit 13 keeps its value across a soft reset. The management logic itself is never cleared by a soft reset; only the asynchronous `rst_ni` clears it.

Top module: `phy_ctrl_reg`

## Requirements
- R1: After `rst_ni` is released, `rd_data_o` reads 16'h1000. This is the default control value: bit 12 is set, and loopback and busy are clear.
- R2: While no reset is running, a write whose bit 15 is 0 stores `wr_data_i[14:0]`. The stored value is readable in `rd_data_o[14:0]` from the next cycle.
- R3: While no reset is running, a write whose bit 15 is 1 makes `rd_data_o[15]` read 1 from the next cycle. The bit stays 1 for exactly RST_CYCLES (default 150) cycles and then clears to 0 by itself.
- R4: A soft reset start loads the defaults (16'h1000) into all of bits 14:0 except bit 13. The write's own bits 14:0 are ignored, and loopback therefore turns off.
- R5: Bit 13 keeps its value from before the soft reset, whatever the starting write carries in bit 13.
- R6: While bit 15 reads 1, writes are ignored. Bits 14:0 do not change, and the reset length is not extended.
- R7: `phy_rst_o` is 1 in exactly the cycles where `rd_data_o[15]` reads 1.
- R8: With bit 14 set, `rx_data_o` equals `tx_data_i`, `rx_dv_o` equals `tx_en_i`, and `line_tx_en_o` and `line_txd_o` are held at 0.
- R9: With bit 14 clear, `line_txd_o` and `line_tx_en_o` follow `tx_data_i` and `tx_en_i`, and `rx_data_o` and `rx_dv_o` follow `line_rxd_i` and `line_rx_dv_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Management write strobe |
| wr_data_i | input | 16 | Management write data |
| rd_data_o | output | 16 | Register read value, bit 15 = reset busy |
| phy_rst_o | output | 1 | Reset strobe to the PHY register set |
| tx_data_i | input | DATA_W | Transmit data from MAC |
| tx_en_i | input | 1 | Transmit enable from MAC |
| line_txd_o | output | DATA_W | Transmit data to the line |
| line_tx_en_o | output | 1 | Transmit enable to the line |
| line_rxd_i | input | DATA_W | Receive data from the line |
| line_rx_dv_i | input | 1 | Receive valid from the line |
| rx_data_o | output | DATA_W | Receive data to MAC |
| rx_dv_o | output | 1 | Receive valid to MAC |

## Verification
The assertions assume that `wr_en_i` and `wr_data_i` are known at every clock edge after reset. They also assume that a reset start is detected only from the port values: a write with bit 15 set while `rd_data_o[15]` reads 0. The bench drives the management and data inputs only on falling edges and returns the strobe to 0 after each write. It also deliberately raises writes with bit 15 set during a running reset, so that the hold and length properties are tested against their own exclusion.

// File: rtl/phy_ctrl_pkg.sv
package phy_ctrl_pkg;
  localparam int unsigned REG_W   = 16;
  localparam int unsigned RST_BIT = 15;
  localparam int unsigned LB_BIT  = 14;

  typedef logic [REG_W-2:0] ctrl_bits_t;

  // value taken on soft reset: retained bits keep old, others go default
  function automatic ctrl_bits_t soft_rst_val(ctrl_bits_t cur, ctrl_bits_t def,
                                              ctrl_bits_t keep);
    return (cur & keep) | (def & ~keep);
  endfunction
endpackage

// File: rtl/phy_ctrl_rst_seq.sv
module phy_ctrl_rst_seq #(
  parameter int unsigned RST_CYCLES = 150
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic wr_rst_bit_i,
  output logic start_o,
  output logic busy_o
);
  localparam int unsigned CNT_W = (RST_CYCLES > 2) ? $clog2(RST_CYCLES) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign start_o = wr_en_i & wr_rst_bit_i & ~busy_q;
  assign busy_o  = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_o) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(RST_CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/phy_ctrl_bits.sv
module phy_ctrl_bits
  import phy_ctrl_pkg::*;
#(
  parameter logic [REG_W-1:0] CTRL_DEF    = 16'h1000,
  parameter logic [REG_W-1:0] RETAIN_MASK = 16'h2000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  ctrl_bits_t wr_bits_i,
  input  logic       start_i,
  input  logic       busy_i,
  output ctrl_bits_t bits_o
);
  localparam ctrl_bits_t DEF  = CTRL_DEF[REG_W-2:0];
  localparam ctrl_bits_t KEEP = RETAIN_MASK[REG_W-2:0];

  ctrl_bits_t rst_val;
  logic       wr_ok;

  assign rst_val = soft_rst_val(bits_o, DEF, KEEP);
  assign wr_ok   = wr_en_i & ~busy_i;

  for (genvar b = 0; b < REG_W - 1; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      bits_o[b] <= DEF[b];
      else if (start_i) bits_o[b] <= rst_val[b];
      else if (wr_ok)   bits_o[b] <= wr_bits_i[b];
    end
  end
endmodule

// File: rtl/phy_ctrl_lb_mux.sv
module phy_ctrl_lb_mux #(
  parameter int unsigned DATA_W = 4
) (
  input  logic              lb_en_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_en_i,
  output logic [DATA_W-1:0] line_txd_o,
  output logic              line_tx_en_o,
  input  logic [DATA_W-1:0] line_rxd_i,
  input  logic              line_rx_dv_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_dv_o
);
  always_comb begin
    if (lb_en_i) begin
      line_txd_o   = '0;
      line_tx_en_o = 1'b0;
      rx_data_o    = tx_data_i;
      rx_dv_o      = tx_en_i;
    end else begin
      line_txd_o   = tx_data_i;
      line_tx_en_o = tx_en_i;
      rx_data_o    = line_rxd_i;
      rx_dv_o      = line_rx_dv_i;
    end
  end
endmodule

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg
  import phy_ctrl_pkg::*;
#(
  parameter int unsigned      DATA_W      = 4,
  parameter int unsigned      RST_CYCLES  = 150,
  parameter logic [REG_W-1:0] CTRL_DEF    = 16'h1000,
  parameter logic [REG_W-1:0] RETAIN_MASK = 16'h2000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [15:0]       wr_data_i,
  output logic [15:0]       rd_data_o,
  output logic              phy_rst_o,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_en_i,
  output logic [DATA_W-1:0] line_txd_o,
  output logic              line_tx_en_o,
  input  logic [DATA_W-1:0] line_rxd_i,
  input  logic              line_rx_dv_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_dv_o
);
  logic       start;
  logic       busy;
  ctrl_bits_t bits;

  phy_ctrl_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_rst_bit_i(wr_data_i[RST_BIT]),
    .start_o     (start),
    .busy_o      (busy)
  );

  phy_ctrl_bits #(.CTRL_DEF(CTRL_DEF), .RETAIN_MASK(RETAIN_MASK)) u_bits (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_bits_i(wr_data_i[REG_W-2:0]),
    .start_i  (start),
    .busy_i   (busy),
    .bits_o   (bits)
  );

  phy_ctrl_lb_mux #(.DATA_W(DATA_W)) u_mux (
    .lb_en_i     (bits[LB_BIT]),
    .tx_data_i   (tx_data_i),
    .tx_en_i     (tx_en_i),
    .line_txd_o  (line_txd_o),
    .line_tx_en_o(line_tx_en_o),
    .line_rxd_i  (line_rxd_i),
    .line_rx_dv_i(line_rx_dv_i),
    .rx_data_o   (rx_data_o),
    .rx_dv_o     (rx_dv_o)
  );

  assign rd_data_o = {busy, bits};
  assign phy_rst_o = busy;
endmodule

// File: rtl/phy_ctrl_reg_chk.sv
module phy_ctrl_reg_chk #(
  parameter int unsigned DATA_W      = 4,
  parameter int unsigned RST_CYCLES  = 150,
  parameter logic [15:0] CTRL_DEF    = 16'h1000,
  parameter logic [15:0] RETAIN_MASK = 16'h2000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [15:0]       wr_data_i,
  input logic [15:0]       rd_data_o,
  input logic              tx_en_i,
  input logic              line_tx_en_o,
  input logic [DATA_W-1:0] line_txd_o
);
  logic        start_seen;
  logic [15:0] busy_run;
  logic [14:0] def_part;

  assign start_seen = wr_en_i & wr_data_i[15] & ~rd_data_o[15];
  assign def_part   = CTRL_DEF[14:0] & ~RETAIN_MASK[14:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           busy_run <= '0;
    else if (rd_data_o[15]) busy_run <= busy_run + 1'b1;
    else                   busy_run <= '0;
  end

  assert_busy_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_seen |=> rd_data_o[15]);

  assert_busy_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_data_o[15]) |-> $past(busy_run) == 16'(RST_CYCLES - 1));

  assert_busy_max_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[15] |-> busy_run < 16'(RST_CYCLES));

  assert_defaults_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_seen |=> (rd_data_o[14:0] & ~RETAIN_MASK[14:0]) == def_part);

  assert_retain_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_seen |=> (rd_data_o[14:0] & RETAIN_MASK[14:0]) ==
                   ($past(rd_data_o[14:0]) & RETAIN_MASK[14:0]));

  assert_busy_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[15] |=> $stable(rd_data_o[14:0]));

  assert_lb_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[14] |-> (!line_tx_en_o && line_txd_o == '0));

  assert_through_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[14] |-> line_tx_en_o == tx_en_i);
endmodule

bind phy_ctrl_reg phy_ctrl_reg_chk #(
  .DATA_W(DATA_W), .RST_CYCLES(RST_CYCLES),
  .CTRL_DEF(CTRL_DEF), .RETAIN_MASK(RETAIN_MASK)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_data_i   (wr_data_i),
  .rd_data_o   (rd_data_o),
  .tx_en_i     (tx_en_i),
  .line_tx_en_o(line_tx_en_o),
  .line_txd_o  (line_txd_o)
);

// File: tb/phy_ctrl_reg_test.sv
module phy_ctrl_reg_test;
  localparam int unsigned DATA_W = 4;
  localparam int unsigned RSTC   = 150;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en_i = 1'b0;
  logic [15:0]       wr_data_i = '0;
  logic [15:0]       rd_data_o;
  logic              phy_rst_o;
  logic [DATA_W-1:0] tx_data_i = '0;
  logic              tx_en_i = 1'b0;
  logic [DATA_W-1:0] line_txd_o;
  logic              line_tx_en_o;
  logic [DATA_W-1:0] line_rxd_i = '0;
  logic              line_rx_dv_i = 1'b0;
  logic [DATA_W-1:0] rx_data_o;
  logic              rx_dv_o;

  int total = 0;
  int bad = 0;

  always #2 clk_i = ~clk_i;

  phy_ctrl_reg #(.DATA_W(DATA_W), .RST_CYCLES(RSTC)) uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write(input logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  // counts busy cycles from current negedge; optional write at busy cycle wr_at
  task automatic run_busy(input int wr_at, input logic [15:0] d, output int n);
    n = 0;
    for (int i = 0; i < 1000 && rd_data_o[15]; i++) begin
      check("R7 rst strobe", phy_rst_o, rd_data_o[15]);
      n++;
      if (n == wr_at) begin wr_en_i = 1'b1; wr_data_i = d; end
      @(negedge clk_i);
      wr_en_i = 1'b0; wr_data_i = '0;
      if (n >= wr_at && wr_at > 0 && rd_data_o[15])
        check("R6 bits held", rd_data_o[14:0], 15'h3000);
    end
    check("R7 strobe low", phy_rst_o, 1'b0);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    check("R1 reset value", rd_data_o, 16'h1000);
    check("R7 no strobe", phy_rst_o, 1'b0);
  endtask

  task automatic t_plain_write();
    write(16'h0ABC);
    check("R2 store", rd_data_o, 16'h0ABC);
    write(16'h2155);
    check("R2 store 2", rd_data_o, 16'h2155);
  endtask

  task automatic t_soft_reset();
    int n;
    write(16'h6ABC);
    check("R2 pre", rd_data_o, 16'h6ABC);
    write(16'h8000);
    check("R3 busy set", rd_data_o[15], 1'b1);
    check("R4 defaults", rd_data_o[14:0] & 15'h5FFF, 15'h1000);
    check("R5 retain 1", rd_data_o[13], 1'b1);
    run_busy(0, '0, n);
    check("R3 length", n, RSTC);
    check("R3 self clear", rd_data_o, 16'h3000);
  endtask

  task automatic t_retain_zero();
    int n;
    write(16'h0000);
    write(16'hFFFF);
    check("R4 write bits ignored", rd_data_o, 16'h9000);
    check("R5 retain 0", rd_data_o[13], 1'b0);
    run_busy(0, '0, n);
    check("R3 length 2", n, RSTC);
  endtask

  task automatic t_busy_ignore();
    int n;
    write(16'h2000);
    write(16'h8000);
    check("R3 busy", rd_data_o, 16'hB000);
    run_busy(20, 16'hC5A5, n);
    check("R6 not extended", n, RSTC);
    check("R6 write dropped", rd_data_o, 16'h3000);
  endtask

  task automatic t_loopback();
    write(16'h4000);
    tx_data_i = 4'hA; tx_en_i = 1'b1; line_rxd_i = 4'h5; line_rx_dv_i = 1'b0;
    @(negedge clk_i);
    check("R8 rx data", rx_data_o, 4'hA);
    check("R8 rx dv", rx_dv_o, 1'b1);
    check("R8 line en", line_tx_en_o, 1'b0);
    check("R8 line data", line_txd_o, 4'h0);
    tx_en_i = 1'b0; tx_data_i = 4'h3; line_rx_dv_i = 1'b1;
    @(negedge clk_i);
    check("R8 rx dv off", rx_dv_o, 1'b0);
    check("R8 rx data 2", rx_data_o, 4'h3);
    write(16'h8000);
    tx_en_i = 1'b1;
    @(negedge clk_i);
    check("R4 loopback off", rd_data_o[14], 1'b0);
    check("R9 after reset", line_tx_en_o, 1'b1);
    repeat (RSTC) @(negedge clk_i);
  endtask

  task automatic t_through();
    write(16'h0000);
    tx_data_i = 4'h6; tx_en_i = 1'b1; line_rxd_i = 4'h9; line_rx_dv_i = 1'b1;
    @(negedge clk_i);
    check("R9 line data", line_txd_o, 4'h6);
    check("R9 line en", line_tx_en_o, 1'b1);
    check("R9 rx data", rx_data_o, 4'h9);
    check("R9 rx dv", rx_dv_o, 1'b1);
    tx_en_i = 1'b0; line_rx_dv_i = 1'b0;
    @(negedge clk_i);
    check("R9 line en off", line_tx_en_o, 1'b0);
    check("R9 rx dv off", rx_dv_o, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_plain_write();
    t_soft_reset();
    t_retain_zero();
    t_busy_ignore();
    t_loopback();
    t_through();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule